// File: doc/BRIEF.md
# TLB Random Replacement Counter

This block holds the free-running counter that picks a victim entry whenever the processor asks for a random write into the translation lookaside buffer. The counter moves down by one on every step pulse, one pulse per retired instruction. It never falls below a fixed floor of 8. A step taken at the floor reloads the ceiling of 63. Entries 0 to 7 are therefore never chosen at random, so software can keep permanent mappings there.

The counter is presented on a 32-bit read port, placed in the bit positions that the register occupies. The block also selects the entry number for a buffer write. A random-write request takes the counter value. An indexed-write request takes the entry field of a supplied index register. The counter has no write path, so the only things that change it are reset and step. The buffer storage itself lies outside this block.

Top module: `tlb_victim_counter`

## Requirements
- R1: The counter value seen on the read port always lies between 8 and 63 inclusive, however long step is held high.
- R2: A clock edge with `rst` high loads 63, and `stepEn` has no effect while `rst` is high.
- R3: A clock edge with `stepEn` high and `rst` low lowers the counter by one. An edge with `stepEn` low leaves it unchanged.
- R4: A step taken while the counter is 8 loads 63. Starting from 12, successive steps give 12, 11, 10, 9, 8, 63, 62.
- R5: `rdData` carries the counter in bits 13:8, and every other bit of `rdData` reads as zero.
- R6: While `tlbwrReq` is high, `wrIndex` equals the counter value in the same cycle. When a step falls in that cycle, this is the value before the step.
- R7: While `tlbwiReq` is high and `tlbwrReq` is low, `wrIndex` equals `indexReg[13:8]`, and the other bits of `indexReg` have no effect. When both requests are high, the random request wins.
- R8: The counter has no write path. Indexed-write requests and any value on `indexReg` leave the counter unchanged.
- R9: `wrIndexValid` is high exactly when `tlbwrReq` or `tlbwiReq` is high, and `wrIndex` reads zero when neither request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stepEn | input | 1 | One pulse per retired instruction |
| tlbwrReq | input | 1 | Random-write request |
| tlbwiReq | input | 1 | Indexed-write request |
| indexReg | input | 32 | Index register contents; the entry number sits in bits 13:8 |
| rdData | output | 32 | Counter value in register position |
| wrIndex | output | 6 | Entry number selected for the buffer write |
| wrIndexValid | output | 1 | High when a write request is present |

## Verification
The counter is a single register, so a step or reset shows on `rdData` in the cycle after the edge that takes it. `wrIndex` and `wrIndexValid` are combinational and follow the request inputs within the same cycle. The bench drives its inputs at the falling edge and samples one nanosecond later. It moves its reference count forward only after the rising edge, so every same-cycle output is compared against the value before the step, and every stepped value is compared one cycle later.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;
  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic load;       // load ceiling value
    logic step;       // decrement with wrap
    logic selRandom;  // write index from counter
    logic selIndex;   // write index from index register
  } cntStrobe_t;
endpackage

// File: rtl/tlbv_ctrl.sv
module tlbv_ctrl
  import tlbv_pkg::*;
(
  input  logic       rst,
  input  logic       stepEn,
  input  logic       tlbwrReq,
  input  logic       tlbwiReq,
  output cntStrobe_t strobe
);
  always_comb begin
    strobe.load      = rst;
    strobe.step      = stepEn & ~rst;
    strobe.selRandom = tlbwrReq;
    strobe.selIndex  = tlbwiReq & ~tlbwrReq;
  end
endmodule

// File: rtl/tlbv_datapath.sv
module tlbv_datapath
  import tlbv_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 6,
  parameter int FIELD_LSB = 8,
  parameter int LOW_BOUND = 8,
  parameter int HIGH_BOUND = 63
) (
  input  logic              clk,
  input  cntStrobe_t        strobe,
  input  logic [DATA_W-1:0] indexReg,
  output logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  wrIndex,
  output logic              wrIndexValid
);
  localparam int FIELD_MSB = FIELD_LSB + IDX_W - 1;
  localparam logic [IDX_W-1:0] LOW_VAL  = IDX_W'(LOW_BOUND);
  localparam logic [IDX_W-1:0] HIGH_VAL = IDX_W'(HIGH_BOUND);

  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] cntNext;
  logic [IDX_W-1:0] idxField;
  logic             unusedIdxBits;

  // Decrement with wrap from the floor back to the ceiling
  always_comb begin
    cntNext = cnt;
    if (strobe.load)      cntNext = HIGH_VAL;
    else if (strobe.step) cntNext = (cnt <= LOW_VAL) ? HIGH_VAL : cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    cnt <= cntNext;
  end

  // Read port: place field, zero elsewhere
  always_comb begin
    rdData = '0;
    rdData[FIELD_MSB:FIELD_LSB] = cnt;
  end

  assign idxField = indexReg[FIELD_MSB:FIELD_LSB];

  generate
    if (FIELD_LSB > 0 && FIELD_MSB < DATA_W - 1) begin : g_bothSides
      assign unusedIdxBits = ^{indexReg[DATA_W-1:FIELD_MSB+1], indexReg[FIELD_LSB-1:0]};
    end else if (FIELD_LSB > 0) begin : g_lowSide
      assign unusedIdxBits = ^indexReg[FIELD_LSB-1:0];
    end else if (FIELD_MSB < DATA_W - 1) begin : g_highSide
      assign unusedIdxBits = ^indexReg[DATA_W-1:FIELD_MSB+1];
    end else begin : g_noSide
      assign unusedIdxBits = 1'b0;
    end
  endgenerate

  // Write index select; counter value is the pre-step register
  always_comb begin
    wrIndex = '0;
    if (strobe.selRandom)     wrIndex = cnt;
    else if (strobe.selIndex) wrIndex = idxField;
    wrIndexValid = strobe.selRandom | strobe.selIndex;
  end
endmodule

// File: rtl/tlb_victim_counter.sv
module tlb_victim_counter
  import tlbv_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 6,
  parameter int FIELD_LSB  = 8,
  parameter int LOW_BOUND  = 8,
  parameter int HIGH_BOUND = 63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stepEn,
  input  logic              tlbwrReq,
  input  logic              tlbwiReq,
  input  logic [DATA_W-1:0] indexReg,
  output logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  wrIndex,
  output logic              wrIndexValid
);
  cntStrobe_t strobe;

  tlbv_ctrl i_ctrl (
    .rst      (rst),
    .stepEn   (stepEn),
    .tlbwrReq (tlbwrReq),
    .tlbwiReq (tlbwiReq),
    .strobe   (strobe)
  );

  tlbv_datapath #(
    .DATA_W     (DATA_W),
    .IDX_W      (IDX_W),
    .FIELD_LSB  (FIELD_LSB),
    .LOW_BOUND  (LOW_BOUND),
    .HIGH_BOUND (HIGH_BOUND)
  ) i_datapath (
    .clk          (clk),
    .strobe       (strobe),
    .indexReg     (indexReg),
    .rdData       (rdData),
    .wrIndex      (wrIndex),
    .wrIndexValid (wrIndexValid)
  );
endmodule

// File: rtl/tlbv_checker.sv
module tlbv_checker #(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 6,
  parameter int FIELD_LSB  = 8,
  parameter int LOW_BOUND  = 8,
  parameter int HIGH_BOUND = 63
) (
  input logic              clk,
  input logic              rst,
  input logic              stepEn,
  input logic              tlbwrReq,
  input logic              tlbwiReq,
  input logic [DATA_W-1:0] indexReg,
  input logic [DATA_W-1:0] rdData,
  input logic [IDX_W-1:0]  wrIndex,
  input logic              wrIndexValid
);
  localparam int FIELD_MSB = FIELD_LSB + IDX_W - 1;
  logic [IDX_W-1:0] fld;
  logic [DATA_W-1:0] outside;
  assign fld = rdData[FIELD_MSB:FIELD_LSB];
  always_comb begin
    outside = rdData;
    outside[FIELD_MSB:FIELD_LSB] = '0;
  end

  assert_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (int'(fld) >= LOW_BOUND && int'(fld) <= HIGH_BOUND));

  assert_reset_load_R2: assert property (@(posedge clk)
    $past(rst) |-> int'(fld) == HIGH_BOUND);

  assert_step_R3_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stepEn)) |->
      (int'(fld) == ((int'($past(fld)) == LOW_BOUND) ? HIGH_BOUND : int'($past(fld)) - 1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(stepEn)) |-> $stable(fld));

  assert_zero_bits_R5: assert property (@(posedge clk) disable iff (rst)
    outside == '0);

  assert_random_sel_R6: assert property (@(posedge clk) disable iff (rst)
    tlbwrReq |-> wrIndex == fld);

  assert_index_sel_R7: assert property (@(posedge clk) disable iff (rst)
    (tlbwiReq && !tlbwrReq) |-> wrIndex == indexReg[FIELD_MSB:FIELD_LSB]);

  assert_valid_R9: assert property (@(posedge clk) disable iff (rst)
    wrIndexValid == (tlbwrReq || tlbwiReq));
endmodule

bind tlb_victim_counter tlbv_checker #(
  .DATA_W     (DATA_W),
  .IDX_W      (IDX_W),
  .FIELD_LSB  (FIELD_LSB),
  .LOW_BOUND  (LOW_BOUND),
  .HIGH_BOUND (HIGH_BOUND)
) i_checker (
  .clk          (clk),
  .rst          (rst),
  .stepEn       (stepEn),
  .tlbwrReq     (tlbwrReq),
  .tlbwiReq     (tlbwiReq),
  .indexReg     (indexReg),
  .rdData       (rdData),
  .wrIndex      (wrIndex),
  .wrIndexValid (wrIndexValid)
);

// File: tb/test_tlb_victim_counter.sv
module test_tlb_victim_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stepEn = 1'b0;
  logic        tlbwrReq = 1'b0;
  logic        tlbwiReq = 1'b0;
  logic [31:0] indexReg = '0;
  logic [31:0] rdData;
  logic [5:0]  wrIndex;
  logic        wrIndexValid;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;
  int expCnt = 63;

  always #2 clk = ~clk;

  tlb_victim_counter i_tlb_victim_counter (
    .clk(clk), .rst(rst), .stepEn(stepEn), .tlbwrReq(tlbwrReq),
    .tlbwiReq(tlbwiReq), .indexReg(indexReg), .rdData(rdData),
    .wrIndex(wrIndex), .wrIndexValid(wrIndexValid)
  );

  function automatic int nextOf(int v);
    return (v == 8) ? 63 : v - 1;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, sample 1 ns later, advance model at rising edge
  task automatic doCycle(bit s, bit wr, bit wi, bit rs, logic [31:0] idx);
    logic [31:0] expRd;
    @(negedge clk);
    stepEn = s; tlbwrReq = wr; tlbwiReq = wi; rst = rs; indexReg = idx;
    #1;
    expRd = 32'(expCnt) << 8;
    chk(rdData == expRd, "R5 read port layout", rdData, expRd);
    chk(int'(rdData[13:8]) >= 8 && int'(rdData[13:8]) <= 63, "R1 range", rdData[13:8], expCnt);
    if (wr)      chk(wrIndex == 6'(expCnt), "R6 random write index", wrIndex, expCnt);
    else if (wi) chk(wrIndex == idx[13:8], "R7 indexed write index", wrIndex, idx[13:8]);
    else         chk(wrIndex == 6'd0, "R9 idle write index", wrIndex, 0);
    chk(wrIndexValid == (wr | wi), "R9 valid", wrIndexValid, wr | wi);
    @(posedge clk);
    if (rs) expCnt = 63;
    else if (s) expCnt = nextOf(expCnt);
  endtask

  task automatic chkField(string tag, int exp);
    @(negedge clk);
    stepEn = 1'b0; tlbwrReq = 1'b0; tlbwiReq = 1'b0; rst = 1'b0;
    #1;
    chk(int'(rdData[13:8]) == exp, tag, rdData[13:8], exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    // Reset held with step high: R2
    doCycle(1, 0, 0, 1, '0);
    doCycle(1, 0, 0, 1, '0);
    chkField("R2 reset value with step held", 63);

    // No step holds value: R3
    doCycle(0, 0, 0, 0, '0);
    chkField("R3 hold without step", 63);
    doCycle(1, 0, 0, 0, '0);
    chkField("R3 single decrement", 62);

    // Walk down to 12, then the wrap sequence: R4
    while (expCnt != 12) doCycle(1, 0, 0, 0, '0);
    chkField("R4 reach 12", 12);
    begin
      int seq [7] = '{12, 11, 10, 9, 8, 63, 62};
      for (int k = 0; k < 7; k++) begin
        chkField("R4 wrap sequence", seq[k]);
        if (k < 6) doCycle(1, 0, 0, 0, '0);
      end
    end

    // Random write with step: pre-step value, R6
    doCycle(1, 1, 0, 0, '0);
    chkField("R6 step after random write", 61);

    // Indexed write with junk bits, no effect on counter: R7, R8
    doCycle(0, 0, 1, 0, 32'hFFFF_C5FF);
    doCycle(0, 0, 1, 0, 32'h0000_0A00);
    chkField("R8 counter unchanged by indexed write", 61);
    // Both requests: random wins, R7
    doCycle(0, 1, 1, 0, 32'h0000_0300);

    // Continuous stepping across several wraps: R1
    repeat (200) doCycle(1, 0, 0, 0, '0);

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit s  = ($urandom % 4) != 0;
      bit wr = ($urandom % 4) == 0;
      bit wi = ($urandom % 4) == 0;
      bit rs = ($urandom % 100) == 0;
      doCycle(s, wr, wi, rs, $urandom);
    end
    chkField("R3 final count", expCnt);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule